// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Persistent Carry

This block combines a combinational 32-bit arithmetic/logic unit with a single carry bit register that keeps its value from one instruction to the next. A small sequencer issues one operation per cycle. It supplies an operation code and two operands, and reads the result in the same cycle. Because the carry persists, chained additions or subtractions can build arithmetic wider than 32 bits. The sequencer pulses `clear_carry` at the start of each program run.

The carry register loads only on a clock edge where `carry_en` is high and the operation is one of the four arithmetic codes. Bitwise operations and unsupported codes never touch the carry. For subtraction, the carry means "no borrow": it is set when the difference did not wrap below zero. The borrowing subtract takes away one extra unit when the carry is clear.

Top module: `carry_alu32`

## Requirements
- R1: Code 0 (add) gives `result = a + b` modulo 2^32. When the flag is updated, carry becomes 1 exactly when the true sum exceeds 0xFFFFFFFF.
- R2: Code 1 (add with carry) gives `result = a + b + carry` modulo 2^32. Carry follows the same overflow rule as R1, applied to the three-term sum.
- R3: Code 2 (subtract) gives `result = a - b` modulo 2^32. When the flag is updated, carry becomes 1 exactly when a >= b (unsigned), meaning no borrow occurred.
- R4: Code 3 (subtract with borrow) gives `result = a - b - (1 - carry)` modulo 2^32. Carry becomes 1 exactly when a >= b + (1 - carry), using unsigned arithmetic without wrap.
- R5: Code 4 gives a XOR b, code 5 gives a OR b, code 6 gives a AND b, code 7 gives a AND NOT b, and code 8 gives NOT (a OR b).
- R6: Codes 4 to 8 leave the carry unchanged, even when `carry_en` is high.
- R7: Codes 9 to 15 give a result of 0 and leave the carry unchanged.
- R8: The carry changes only on an edge where `carry_en` is high. When `carry_en` is low, the result is still computed from the current carry.
- R9: A high `clear_carry` sets the carry to 0 at the next rising edge. It takes priority over an update in the same cycle.
- R10: A synchronous active-high `rst` sets the carry to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_carry | input | 1 | Synchronous clear of the carry flag |
| carry_en | input | 1 | Allows the carry to load from an arithmetic operation |
| op | input | 4 | Operation code (see R1 to R7) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| carry | output | 1 | Current carry flag |

## Verification
The clear and the flag update can both be asserted on the same edge. The bench provokes this by driving an overflowing add with `carry_en` and `clear_carry` both high. It then judges the outcome by requiring the carry seen in the following cycle to be 0, not 1. A second same-cycle pairing is that the result of a carry-consuming code uses the old carry while that same edge loads a new one. The scoreboard checks this by sampling the result before the edge and the carry after it.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_XOR  = 4'd4,
        OP_OR   = 4'd5,
        OP_AND  = 4'd6,
        OP_ANDN = 4'd7,
        OP_NOR  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic invert_b;
        logic use_carry;
        logic fixed_cin;
    } arith_ctl_t;

    function automatic logic op_is_arith(input logic [OP_W-1:0] code);
        return code <= OP_SUBB;
    endfunction

    function automatic logic op_is_logic(input logic [OP_W-1:0] code);
        return (code >= OP_XOR) && (code <= OP_NOR);
    endfunction

    function automatic arith_ctl_t arith_ctl(input logic [OP_W-1:0] code);
        arith_ctl_t c;
        c.invert_b  = (code == OP_SUB) || (code == OP_SUBB);
        c.use_carry = (code == OP_ADDC) || (code == OP_SUBB);
        c.fixed_cin = (code == OP_SUB);
        return c;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned EXT_W = W + 1;

    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] total;

    always_comb begin
        b_ext = {1'b0, (invert_b ? ~b : b)};
        total = {1'b0, a} + b_ext + {{(EXT_W-1){1'b0}}, cin};
    end

    assign sum  = total[W-1:0];
    assign cout = total[EXT_W-1];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import carry_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    always_comb begin
        case (op)
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_ANDN: y = a & ~b;
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_carry_reg.sv
module alu_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (load) begin
            q <= d;
        end
    end

    // R9: clear wins over any load on the same edge
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);

    // R8: no load, no clear -> flag holds
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load) |=> $stable(q));
endmodule

// File: rtl/carry_alu32.sv
module carry_alu32
    import carry_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_carry,
    input  logic              carry_en,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    arith_ctl_t        ctl;
    logic              cin;
    logic [DATA_W-1:0] arith_out;
    logic              arith_cout;
    logic [DATA_W-1:0] logic_out;
    logic              is_arith;
    logic              is_logic;
    logic              flag_load;

    always_comb begin
        ctl      = arith_ctl(op);
        is_arith = op_is_arith(op);
        is_logic = op_is_logic(op);
        cin      = ctl.use_carry ? carry : ctl.fixed_cin;
    end

    alu_adder #(.W(DATA_W)) u_adder (
        .a        (opnd_a),
        .b        (opnd_b),
        .invert_b (ctl.invert_b),
        .cin      (cin),
        .sum      (arith_out),
        .cout     (arith_cout)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_out)
    );

    assign flag_load = carry_en && is_arith;

    alu_carry_reg u_flag (
        .clk  (clk),
        .rst  (rst),
        .clr  (clear_carry),
        .load (flag_load),
        .d    (arith_cout),
        .q    (carry)
    );

    always_comb begin
        if (is_arith)      result = arith_out;
        else if (is_logic) result = logic_out;
        else               result = '0;
    end

    // Independent reference terms for the checks below
    logic [DATA_W:0] chk_plain_sum;
    assign chk_plain_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    // R1: add overflow loads into the flag
    assert_add_carry_R1: assert property (@(posedge clk) disable iff (rst)
        (carry_en && !clear_carry && op == OP_ADD) |=> carry == $past(chk_plain_sum[DATA_W]));

    // R3: subtract flag means a >= b
    assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (rst)
        (carry_en && !clear_carry && op == OP_SUB) |=> carry == $past(opnd_a >= opnd_b));

    // R6: bitwise codes never move the flag
    assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (!clear_carry && op >= OP_XOR) |=> $stable(carry));

    // R7: unsupported codes yield zero
    assert_unsupported_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (op > OP_NOR) |-> result == '0);
endmodule

// File: tb/carry_alu32_test.sv
module carry_alu32_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear_carry = 1'b0;
    logic        carry_en = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        carry;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] q_res[$];
    logic        q_car[$];
    string       q_req[$];
    logic        model_c = 1'b0;

    always #10 clk = ~clk;

    carry_alu32 uut (
        .clk(clk), .rst(rst), .clear_carry(clear_carry), .carry_en(carry_en),
        .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .carry(carry)
    );

    // Driver: applies one operation per cycle and pushes expectations
    task automatic issue(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b,
                         input logic en, input logic clr, input logic rs, input string req);
        logic [31:0] r;
        logic        nc;
        longint      ua, ub, uc;
        @(negedge clk);
        op = code; opnd_a = a; opnd_b = b; carry_en = en; clear_carry = clr; rst = rs;
        ua = longint'(a); ub = longint'(b); uc = model_c ? 1 : 0;
        nc = model_c;
        case (code)
            4'd0: begin r = 32'(ua + ub);          nc = (ua + ub) > 64'hFFFF_FFFF; end
            4'd1: begin r = 32'(ua + ub + uc);     nc = (ua + ub + uc) > 64'hFFFF_FFFF; end
            4'd2: begin r = 32'(ua - ub);          nc = ua >= ub; end
            4'd3: begin r = 32'(ua - ub - (1 - uc)); nc = ua >= ub + (1 - uc); end
            4'd4: r = a ^ b;
            4'd5: r = a | b;
            4'd6: r = a & b;
            4'd7: r = a & ~b;
            4'd8: r = ~(a | b);
            default: r = 32'd0;
        endcase
        q_res.push_back(r);
        q_car.push_back(model_c);
        q_req.push_back(req);
        if (rs || clr)                 model_c = 1'b0;
        else if (en && code <= 4'd3)   model_c = nc;
    endtask

    // Monitor: compares mid low phase, after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q_res.size() > 0) begin
                logic [31:0] er;
                logic        ec;
                string       rq;
                er = q_res.pop_front();
                ec = q_car.pop_front();
                rq = q_req.pop_front();
                checks++;
                if (result !== er) begin
                    errors++;
                    $display("FAIL %s result actual=%h expected=%h", rq, result, er);
                end
                checks++;
                if (carry !== ec) begin
                    errors++;
                    $display("FAIL %s carry actual=%b expected=%b", rq, carry, ec);
                end
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R10: state after reset
        issue(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R10");
        // R1 add
        issue(4'd0, 32'd5, 32'd7, 1'b1, 1'b0, 1'b0, "R1");
        issue(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, 1'b0, "R1");
        // R2 add with carry
        issue(4'd1, 32'd1, 32'd2, 1'b1, 1'b0, 1'b0, "R2");
        issue(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R1");
        issue(4'd1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0, "R2");
        issue(4'd1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, "R2");
        // R3 subtract
        issue(4'd2, 32'd10, 32'd3, 1'b1, 1'b0, 1'b0, "R3");
        issue(4'd2, 32'd3, 32'd10, 1'b1, 1'b0, 1'b0, "R3");
        issue(4'd2, 32'd5, 32'd5, 1'b1, 1'b0, 1'b0, "R3");
        // R4 subtract with borrow
        issue(4'd3, 32'd10, 32'd3, 1'b1, 1'b0, 1'b0, "R4");
        issue(4'd2, 32'd0, 32'd1, 1'b1, 1'b0, 1'b0, "R3");
        issue(4'd3, 32'd10, 32'd3, 1'b1, 1'b0, 1'b0, "R4");
        issue(4'd2, 32'd0, 32'd1, 1'b1, 1'b0, 1'b0, "R3");
        issue(4'd3, 32'd5, 32'd5, 1'b1, 1'b0, 1'b0, "R4");
        issue(4'd3, 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, "R4");
        // R5/R6 bitwise with flag enabled, carry currently 0 then 1
        issue(4'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 1'b0, 1'b0, "R5");
        issue(4'd2, 32'd9, 32'd1, 1'b1, 1'b0, 1'b0, "R3");
        issue(4'd5, 32'hA000_0001, 32'h0500_0010, 1'b1, 1'b0, 1'b0, "R6");
        issue(4'd6, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b0, "R5");
        issue(4'd7, 32'hFFFF_0000, 32'h00FF_FF00, 1'b1, 1'b0, 1'b0, "R5");
        issue(4'd8, 32'h0000_00FF, 32'hFF00_0000, 1'b1, 1'b0, 1'b0, "R6");
        // R7 unsupported codes
        issue(4'd9, 32'h1234_5678, 32'd1, 1'b1, 1'b0, 1'b0, "R7");
        issue(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R7");
        // R8 update disabled
        issue(4'd2, 32'd1, 32'd2, 1'b0, 1'b0, 1'b0, "R8");
        issue(4'd1, 32'd4, 32'd4, 1'b0, 1'b0, 1'b0, "R8");
        // R9 clear, and clear against a same-cycle overflow
        issue(4'd0, 32'hFFFF_FFFF, 32'd2, 1'b1, 1'b1, 1'b0, "R9");
        issue(4'd0, 32'hFFFF_FFFF, 32'd2, 1'b1, 1'b0, 1'b0, "R9");
        issue(4'd4, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, "R9");
        // R10 reset mid-run
        issue(4'd0, 32'hFFFF_FFFF, 32'd2, 1'b1, 1'b0, 1'b0, "R10");
        issue(4'd0, 32'hFFFF_FFFF, 32'd2, 1'b1, 1'b0, 1'b1, "R10");
        issue(4'd1, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R10");
        // flush so the final carry is compared
        issue(4'd15, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, "R7");
        wait (q_res.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule